// File: doc/BRIEF.md
# Split-Operand Binomial Cube Unit

This unit raises a 16-bit unsigned operand to the third power and returns the exact 48-bit result. It never chains two wide multiplications. The operand is cut into a high byte H and a low byte L. The cube is then rebuilt from the binomial expansion:

`H^3·2^24 + 3·H^2·L·2^16 + 3·H·L^2·2^8 + L^3`

The byte squares are formed by a pairwise-product squarer. The byte cubes and the two cross terms come from narrow 16x8 multipliers. The factor of three is applied by adding the value to a copy of itself shifted left by one bit.

The unit has two register stages. The first stage holds the byte squares and byte cubes. The second stage holds the cross terms, tripled and aligned, summed with the byte cubes. An operand can be accepted on every clock. Each result leaves two clocks after the operand arrives and is flagged by a valid pulse. The output holds its last value until a new result replaces it.

Top module: `cube_split16`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `res_vld` and `cube_res` are both 0 after that edge (synchronous active-low reset).
- R2: For any operand accepted with `op_vld` high, `cube_res` equals the operand cubed as an exact 48-bit unsigned value, with no carry lost. This includes the operands 0, 1, 255, 256 and 65535.
- R3: The times-three unit returns a value W+2 bits wide equal to X+X+X for every W-bit input X.
- R4: `res_vld` is high after the edge exactly two rising edges after the edge at which `op_vld` was high. It is never high otherwise.
- R5: Operands presented on consecutive clocks are all accepted. Their results appear on consecutive clocks, in the same order.
- R6: A clock edge with `op_vld` low leaves `cube_res` unchanged two edges later, whatever value `op_in` carries at that edge.
- R7: The high byte is `op_in[15:8]` and carries weight 2^8. An operand whose low byte is zero gives H^3·2^24. An operand whose high byte is zero gives L^3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_vld | input | 1 | Operand strobe, sampled at each rising edge |
| op_in | input | 16 | Unsigned operand |
| res_vld | output | 1 | High for one cycle per result, two clocks after `op_vld` |
| cube_res | output | 48 | Cube of the operand; holds between results |

## Verification
Two functions can fall in the same cycle: accepting a fresh operand into the first stage, and retiring an earlier operand from the second stage. The bench provokes this by streaming operands on back-to-back clocks. It checks that each result matches the cube of the operand sent two clocks before, and that the order is kept. The bench also idles the strobe while the operand lines keep changing, and checks that the held result does not move.

// File: rtl/cube_pkg.sv
// Package: shared sizing defaults for the split-operand cube unit.
// Assumes: the operand is split into two equal unsigned parts.
package cube_pkg;
    parameter int CUBE_PART_W = 8;
    localparam int CUBE_OP_W  = 2 * CUBE_PART_W;
    localparam int CUBE_RES_W = 3 * CUBE_OP_W;
endpackage

// File: rtl/cube_sq.sv
// Module: combinational squarer built from pairwise bit products.
// Each bit contributes itself at weight 2^(2i). Each pair i<j contributes
// its AND at weight 2^(i+j+1), which is twice the cross product.
// Assumes: unsigned input; the output is 2*W bits and cannot overflow.
module cube_sq #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a_i,
    output logic [2*W-1:0] sq_o
);
    localparam int OW = 2 * W;

    // Sum of the self terms and the doubled pair terms.
    always_comb begin
        sq_o = '0;
        for (int i = 0; i < W; i++) begin
            sq_o = sq_o + (OW'(a_i[i]) << (2 * i));
            for (int j = i + 1; j < W; j++) begin
                sq_o = sq_o + (OW'(a_i[i] & a_i[j]) << (i + j + 1));
            end
        end
    end
endmodule

// File: rtl/cube_umul.sv
// Module: combinational unsigned multiplier made of shifted partial products.
// Assumes: unsigned operands; the output is AW+BW bits wide and cannot overflow.
module cube_umul #(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic [AW-1:0]    a_i,
    input  logic [BW-1:0]    b_i,
    output logic [AW+BW-1:0] p_o
);
    localparam int PW = AW + BW;

    logic [PW-1:0] pp [BW];

    // One partial product for each multiplier bit.
    for (genvar g = 0; g < BW; g++) begin : g_pp
        assign pp[g] = b_i[g] ? (PW'(a_i) << g) : '0;
    end

    // Add the partial products together.
    always_comb begin
        p_o = '0;
        for (int i = 0; i < BW; i++) begin
            p_o = p_o + pp[i];
        end
    end
endmodule

// File: rtl/cube_x3.sv
// Module: constant multiply by three, formed as X + (X << 1).
// Assumes: unsigned input; two guard bits keep the full result.
module cube_x3 #(
    parameter int W = 24
) (
    input  logic [W-1:0]   x_i,
    output logic [W+1:0]   y_o
);
    localparam int OW = W + 2;

    assign y_o = OW'(x_i) + (OW'(x_i) << 1);

    // Check the shifted sum against plain repeated addition.
    always_comb begin
        if (!$isunknown(x_i)) begin
            a_r3_triple: assert (y_o == OW'(x_i) + OW'(x_i) + OW'(x_i))
                else $error("R3: triple mismatch");
        end
    end
endmodule

// File: rtl/cube_split16.sv
// Module: two-stage cube of an unsigned operand, built from its two halves.
// Stage 1 registers the half squares and half cubes. Stage 2 forms the
// tripled cross terms and registers the aligned 48-bit sum.
// Assumes: synchronous active-low reset; one operand may be accepted per clock.
module cube_split16 #(
    parameter int PART_W = cube_pkg::CUBE_PART_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_vld,
    input  logic [2*PART_W-1:0] op_in,
    output logic                res_vld,
    output logic [6*PART_W-1:0] cube_res
);
    localparam int OP_W  = 2 * PART_W;
    localparam int SQ_W  = 2 * PART_W;
    localparam int CU_W  = 3 * PART_W;
    localparam int TR_W  = CU_W + 2;
    localparam int RES_W = 3 * OP_W;

    logic [PART_W-1:0] hi_part, lo_part;
    logic [SQ_W-1:0]   sq_hi, sq_lo;
    logic [CU_W-1:0]   cu_hi, cu_lo;

    assign hi_part = op_in[OP_W-1:PART_W];
    assign lo_part = op_in[PART_W-1:0];

    cube_sq   #(.W(PART_W))              u_sq_hi (.a_i(hi_part), .sq_o(sq_hi));
    cube_sq   #(.W(PART_W))              u_sq_lo (.a_i(lo_part), .sq_o(sq_lo));
    cube_umul #(.AW(SQ_W), .BW(PART_W))  u_cu_hi (.a_i(sq_hi), .b_i(hi_part), .p_o(cu_hi));
    cube_umul #(.AW(SQ_W), .BW(PART_W))  u_cu_lo (.a_i(sq_lo), .b_i(lo_part), .p_o(cu_lo));

    logic              s1_vld;
    logic [PART_W-1:0] s1_hi, s1_lo;
    logic [SQ_W-1:0]   s1_sq_hi, s1_sq_lo;
    logic [CU_W-1:0]   s1_cu_hi, s1_cu_lo;

    // Stage 1: capture the halves, their squares and their cubes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_hi    <= '0;
            s1_lo    <= '0;
            s1_sq_hi <= '0;
            s1_sq_lo <= '0;
            s1_cu_hi <= '0;
            s1_cu_lo <= '0;
        end else begin
            s1_vld <= op_vld;
            if (op_vld) begin
                s1_hi    <= hi_part;
                s1_lo    <= lo_part;
                s1_sq_hi <= sq_hi;
                s1_sq_lo <= sq_lo;
                s1_cu_hi <= cu_hi;
                s1_cu_lo <= cu_lo;
            end
        end
    end

    logic [CU_W-1:0]  cross_hhl, cross_hll;
    logic [TR_W-1:0]  trip_hhl, trip_hll;
    logic [RES_W-1:0] sum_nxt;

    cube_umul #(.AW(SQ_W), .BW(PART_W)) u_cr_hhl (.a_i(s1_sq_hi), .b_i(s1_lo), .p_o(cross_hhl));
    cube_umul #(.AW(SQ_W), .BW(PART_W)) u_cr_hll (.a_i(s1_sq_lo), .b_i(s1_hi), .p_o(cross_hll));
    cube_x3   #(.W(CU_W))               u_x3_hhl (.x_i(cross_hhl), .y_o(trip_hhl));
    cube_x3   #(.W(CU_W))               u_x3_hll (.x_i(cross_hll), .y_o(trip_hll));

    // Align each term by the weight of its halves and add, right to left.
    always_comb begin
        sum_nxt = RES_W'(s1_cu_lo)
                + (RES_W'(trip_hll) << PART_W)
                + (RES_W'(trip_hhl) << (2 * PART_W))
                + (RES_W'(s1_cu_hi) << (3 * PART_W));
    end

    // Stage 2: register the finished cube; hold it when no result is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            cube_res <= '0;
        end else begin
            res_vld <= s1_vld;
            if (s1_vld) begin
                cube_res <= sum_nxt;
            end
        end
    end

    // R4: a strobe yields a valid result exactly two clocks later.
    a_r4_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |=> ##1 res_vld)
        else $error("R4: missing valid");

    // R4: no valid result without a strobe two clocks earlier.
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(op_vld, 2))
        else $error("R4: spurious valid");

    // R6: the result holds when no operand moved into stage 2.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> $stable(cube_res))
        else $error("R6: result moved");

    // R2: a zero operand gives a zero cube.
    a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_in == '0) |=> ##1 (cube_res == '0))
        else $error("R2: zero cube");
endmodule

// File: tb/test_cube_split16.sv
// Bench: directed tests for cube_split16, one task per scenario.
module test_cube_split16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_vld = 1'b0;
    logic [15:0] op_in = '0;
    logic        res_vld;
    logic [47:0] cube_res;
    logic [7:0]  x3_in = '0;
    logic [9:0]  x3_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cube_split16 i_cube_split16 (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_in(op_in),
        .res_vld(res_vld), .cube_res(cube_res)
    );

    cube_x3 #(.W(8)) i_x3_solo (.x_i(x3_in), .y_o(x3_out));

    function automatic logic [47:0] ref_cube(input logic [15:0] v);
        return 48'(v) * 48'(v) * 48'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe one operand, then sample two clocks later.
    task automatic one_op(input logic [15:0] v, input string req);
        @(negedge clk); op_vld = 1'b1; op_in = v;
        @(negedge clk); op_vld = 1'b0; op_in = ~v;
        chk(res_vld == 1'b0, "R4 early", 64'(res_vld), 64'd0);
        @(negedge clk);
        chk(res_vld == 1'b1, "R4 valid", 64'(res_vld), 64'd1);
        chk(cube_res == ref_cube(v), req, 64'(cube_res), 64'(ref_cube(v)));
        @(negedge clk);
        chk(res_vld == 1'b0, "R4 pulse", 64'(res_vld), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(res_vld == 1'b0, "R1 valid", 64'(res_vld), 64'd0);
        chk(cube_res == '0, "R1 result", 64'(cube_res), 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_triple();
        for (int i = 0; i < 256; i++) begin
            x3_in = 8'(i);
            #1;
            chk(x3_out == 10'(i) + 10'(i) + 10'(i), "R3", 64'(x3_out), 64'(3 * i));
        end
    endtask

    task automatic t_corners();
        one_op(16'h0000, "R2 zero");
        one_op(16'h0001, "R2 one");
        one_op(16'h00FF, "R2 255");
        one_op(16'h0100, "R2 256");
        one_op(16'hFFFF, "R2 max");
        one_op(16'hAB00, "R7 high only");
        one_op(16'h00CD, "R7 low only");
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++) begin
            one_op(16'($urandom), "R2 random");
        end
    endtask

    task automatic t_stream();
        logic [15:0] q [0:19];
        for (int i = 0; i < 20; i++) q[i] = 16'($urandom);
        for (int i = 0; i < 22; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk(res_vld == 1'b1, "R5 valid", 64'(res_vld), 64'd1);
                chk(cube_res == ref_cube(q[i-2]), "R5 order", 64'(cube_res), 64'(ref_cube(q[i-2])));
            end
            op_vld = (i < 20);
            op_in  = (i < 20) ? q[i] : 16'h0;
        end
        op_vld = 1'b0;
    endtask

    task automatic t_hold();
        logic [47:0] held;
        one_op(16'h1234, "R2 pre-hold");
        held = cube_res;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); op_vld = 1'b0; op_in = 16'($urandom);
        end
        @(negedge clk);
        chk(cube_res == held, "R6 hold", 64'(cube_res), 64'(held));
        chk(res_vld == 1'b0, "R6 no valid", 64'(res_vld), 64'd0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_triple();
                t_corners();
                t_random();
                t_stream();
                t_hold();
                t_reset();
            end
            begin
                repeat (50000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule